// File: doc/BRIEF.md
# Multiplexed IO Bus Cycle Master

This block runs one read or one write cycle at a time on an 8-bit IO bus whose 16-bit port address shares a single 8-bit address bus. On a start request it first places the upper address byte on the bus and pulses a strobe low. An external latch captures the byte on the strobe's rising edge. The block then places the lower byte on the same bus and keeps it there until the cycle ends. After a short setup gap it lowers the IO request strobe together with the read or the write strobe.

Every cycle includes a wait state. The strobes stay low while the device holds the WAIT line low, and the block moves on only after it sees the line high through a synchroniser. In a read, the data bus is sampled before the strobes are released. In a write, the block drives the data bus before the strobes fall and stops driving it only after both strobes have returned high. A one-cycle done pulse ends each transaction.

Top module: `iobus_cycle_master`

## Requirements
- R1: After an accepted start, `abus` carries addr[15:8] first. `hi_stb_n` is then low for exactly one cycle, and the external latch captures `abus` on its rising edge. After that, `abus` carries addr[7:0] until the IO request strobe falls and throughout the strobe phase.
- R2: During and after reset, and whenever the block is idle, `iorq_n`, `rd_n`, `wr_n` and `hi_stb_n` are high, `dbus_oe` is low and `done` is low.
- R3: `iorq_n` falls exactly SETUP_CYC cycles after addr[7:0] appears on `abus`, which is SETUP_CYC+1 cycles after `hi_stb_n` rises. In a read (`wr_sel`=0), `rd_n` falls in the same cycle and `wr_n` stays high.
- R4: In a write (`wr_sel`=1), `dbus_oe` is already high and `dbus` already carries the write byte when `wr_n` and `iorq_n` fall together. `rd_n` stays high for the whole write. `rd_n` and `wr_n` are never low at the same time.
- R5: The read or write strobe stays low for at least STROBE_MIN cycles. It also stays low for as long as the synchronised WAIT level is low.
- R6: In a read, `rdata` holds the value of `dbus` sampled after WAIT is seen high and before `rd_n` rises.
- R7: Strobes are released in a fixed order. `rd_n`/`wr_n` rises first, and `iorq_n` rises exactly one cycle later. The read or write strobe is never low while `iorq_n` is high.
- R8: In a write, `dbus_oe` falls exactly one cycle after `iorq_n` rises. `dbus_oe` is never high during a read.
- R9: `done` is high for exactly one cycle, in the cycle after `iorq_n` rises. A start request that arrives while a transaction is in progress is ignored.
- R10: `bus_wait_n` passes through SYNC_STAGES flops (default 2). When the strobe minimum is already met, the read or write strobe rises SYNC_STAGES+2 cycles after `bus_wait_n` goes high, which is 4 cycles at the default setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transaction; accepted only while idle |
| wr_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | ADDR_W | Port address |
| wdata | input | DATA_W | Byte to write |
| bus_wait_n | input | 1 | Bus WAIT line, low = hold the cycle |
| abus | output | ADDR_W/2 | Shared address bus (high byte, then low byte) |
| hi_stb_n | output | 1 | High-byte latch strobe, active low |
| iorq_n | output | 1 | IO request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dbus | inout | DATA_W | Tri-state data bus |
| dbus_oe | output | 1 | High while the block drives `dbus` |
| rdata | output | DATA_W | Byte captured by the last read |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
A state machine that takes a wrong step shows it at the strobes in the same cycle or the next one. A skipped latch phase leaves the wrong upper byte in the external latch when `hi_stb_n` rises. A wrong setup count or an early exit from the wait state shifts the fall or rise of `iorq_n`, `rd_n` or `wr_n` by whole cycles, and the bench measures those cycles exactly. It uses a different WAIT stretch for every cycle. A stale capture register or a late capture shows up in `rdata` by the time the read strobe rises. A data-bus enable left in the wrong state is visible in `dbus_oe` either at the write strobe's edges or at the done pulse.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR_HI,
      ST_LATCH,
      ST_ADDR_LO,
      ST_GAP,
      ST_ACTIVE,
      ST_REL_RW,
      ST_REL_IO,
      ST_FINISH
   } iob_state_e;

   function automatic int iob_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/iobus_wait_sync.sv
module iobus_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("iobus_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b1;
               else     chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[s] <= 1'b1;
               else     chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/iobus_down_timer.sv
module iobus_down_timer #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             zero
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("iobus_down_timer: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)             cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/iobus_data_port.sv
module iobus_data_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wd_load,
   input  logic [DATA_W-1:0] wd,
   input  logic              drive_on,
   input  logic              drive_off,
   input  logic              capture,
   inout  wire  [DATA_W-1:0] dbus,
   output logic [DATA_W-1:0] rdata,
   output logic              oe
);
   logic [DATA_W-1:0] dout_q;
   logic [DATA_W-1:0] rdata_q;
   logic              oe_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q  <= '0;
         rdata_q <= '0;
         oe_q    <= 1'b0;
      end else begin
         if (wd_load)        dout_q  <= wd;
         if (capture)        rdata_q <= dbus;
         if (drive_off)      oe_q    <= 1'b0;
         else if (drive_on)  oe_q    <= 1'b1;
      end
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_pad
         assign dbus[b] = oe_q ? dout_q[b] : 1'bz;
      end
   endgenerate

   assign rdata = rdata_q;
   assign oe    = oe_q;

   // R8: the enable is never raised in the same cycle it is dropped
   a_r8_oe_ctrl_excl: assert property (@(posedge clk) disable iff (rst)
      drive_off |-> !drive_on);

endmodule

// File: rtl/iobus_cycle_master.sv
module iobus_cycle_master
   import iobus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SETUP_CYC   = 2,
   parameter int STROBE_MIN  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic                  wr_sel,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  bus_wait_n,
   output logic [ADDR_W/2-1:0]   abus,
   output logic                  hi_stb_n,
   output logic                  iorq_n,
   output logic                  rd_n,
   output logic                  wr_n,
   inout  wire  [DATA_W-1:0]     dbus,
   output logic                  dbus_oe,
   output logic [DATA_W-1:0]     rdata,
   output logic                  done
);
   localparam int HALF    = ADDR_W / 2;
   localparam int TMR_MAX = iob_max(SETUP_CYC, STROBE_MIN);
   localparam int TMR_W   = iob_max($clog2(TMR_MAX + 1), 1);

   generate
      if (ADDR_W % 2 != 0) begin : g_bad_addr
         $error("iobus_cycle_master: ADDR_W must be even");
      end
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("iobus_cycle_master: SETUP_CYC must be at least 1");
      end
      if (STROBE_MIN < 1) begin : g_bad_strobe
         $error("iobus_cycle_master: STROBE_MIN must be at least 1");
      end
   endgenerate

   iob_state_e       st_q;
   logic [HALF-1:0]  abus_q;
   logic [HALF-1:0]  lo_q;
   logic             wr_q;
   logic             hlat_q, iorq_q, rd_q, wrs_q, done_q;

   logic             wait_s;
   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             go_release;

   iobus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(bus_wait_n), .sync_out(wait_s)
   );

   always_comb begin
      tmr_load = (st_q == ST_ADDR_LO) || ((st_q == ST_GAP) && tmr_zero);
      tmr_val  = (st_q == ST_ADDR_LO) ? TMR_W'(SETUP_CYC - 1) : TMR_W'(STROBE_MIN - 1);
   end

   iobus_down_timer #(.WIDTH(TMR_W)) u_tmr (
      .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   assign go_release = (st_q == ST_ACTIVE) && tmr_zero && wait_s;

   iobus_data_port #(.DATA_W(DATA_W)) u_dport (
      .clk      (clk),
      .rst      (rst),
      .wd_load  ((st_q == ST_IDLE) && start),
      .wd       (wdata),
      .drive_on ((st_q == ST_ADDR_LO) && wr_q),
      .drive_off(st_q == ST_FINISH),
      .capture  (go_release && !wr_q),
      .dbus     (dbus),
      .rdata    (rdata),
      .oe       (dbus_oe)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         abus_q <= '0;
         lo_q   <= '0;
         wr_q   <= 1'b0;
         hlat_q <= 1'b1;
         iorq_q <= 1'b1;
         rd_q   <= 1'b1;
         wrs_q  <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               abus_q <= addr[ADDR_W-1:HALF];
               lo_q   <= addr[HALF-1:0];
               wr_q   <= wr_sel;
               st_q   <= ST_ADDR_HI;
            end
            ST_ADDR_HI: begin
               hlat_q <= 1'b0;
               st_q   <= ST_LATCH;
            end
            ST_LATCH: begin
               hlat_q <= 1'b1;
               st_q   <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
               abus_q <= lo_q;
               st_q   <= ST_GAP;
            end
            ST_GAP: if (tmr_zero) begin
               iorq_q <= 1'b0;
               if (wr_q) wrs_q <= 1'b0;
               else      rd_q  <= 1'b0;
               st_q   <= ST_ACTIVE;
            end
            ST_ACTIVE: if (go_release) st_q <= ST_REL_RW;
            ST_REL_RW: begin
               rd_q  <= 1'b1;
               wrs_q <= 1'b1;
               st_q  <= ST_REL_IO;
            end
            ST_REL_IO: begin
               iorq_q <= 1'b1;
               st_q   <= ST_FINISH;
            end
            ST_FINISH: begin
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign abus     = abus_q;
   assign hi_stb_n = hlat_q;
   assign iorq_n   = iorq_q;
   assign rd_n     = rd_q;
   assign wr_n     = wrs_q;
   assign done     = done_q;

   // R2: idle means all strobes released and the bus undriven
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE) |-> (iorq_n && rd_n && wr_n && hi_stb_n && !dbus_oe));

   // R1: latch strobe low for a single cycle
   a_r1_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
      !hi_stb_n |=> hi_stb_n);

   // R4: read and write strobes are mutually exclusive
   a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> wr_n);

   // R4: bus already driven when the write strobe falls
   a_r4_drive_before_wr: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_n) |-> dbus_oe);

   // R5: while synchronised WAIT is low the strobe stays low
   a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
      ((st_q == ST_ACTIVE) && !wait_s) |=> (!iorq_n && !(rd_n && wr_n)));

   // R7: read/write strobe only inside an IO request
   a_r7_rw_inside_io: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !wr_n) |-> !iorq_n);

   // R7: IO request released a cycle after read/write
   a_r7_io_after_rw: assert property (@(posedge clk) disable iff (rst)
      $rose(iorq_n) |-> (rd_n && wr_n && $past(rd_n && wr_n)));

   // R8: no drive during a read strobe
   a_r8_no_drive_in_read: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !dbus_oe);

   // R8: enable drops only after IO request has been high a cycle
   a_r8_oe_after_io: assert property (@(posedge clk) disable iff (rst)
      $fell(dbus_oe) |-> (iorq_n && $past(iorq_n)));

   // R9: done lasts one cycle and arrives with the bus quiet
   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
      done |-> (iorq_n && !dbus_oe && $past(iorq_n)));

endmodule

// File: tb/iobus_cycle_master_test.sv
module iobus_cycle_master_test;
   localparam int SETUP = 2;
   localparam int STRB  = 3;

   typedef struct {
      bit          wr;
      logic [15:0] addr;
      logic [7:0]  data;
   } item_t;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst = 1'b1;
   logic        start = 1'b0, wr_sel = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        bus_wait_n;
   logic [7:0]  abus;
   logic        hi_stb_n, iorq_n, rd_n, wr_n, dbus_oe, done;
   logic [7:0]  rdata;
   wire  [7:0]  dbus;

   int checks = 0, errors = 0, cyc = 0;
   int n_issued = 0, n_done = 0, hl_falls = 0;

   iobus_cycle_master #(.SETUP_CYC(SETUP), .STROBE_MIN(STRB)) uut (
      .clk(clk), .rst(rst), .start(start), .wr_sel(wr_sel), .addr(addr),
      .wdata(wdata), .bus_wait_n(bus_wait_n), .abus(abus), .hi_stb_n(hi_stb_n),
      .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .dbus(dbus), .dbus_oe(dbus_oe),
      .rdata(rdata), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dflt(input logic [15:0] a);
      return a[7:0] ^ ~a[15:8];
   endfunction

   // ---------------- port model ----------------
   logic [7:0] hi_latch = '0;
   logic [7:0] pm [logic [15:0]];
   logic [7:0] dev_drv = '0;
   logic       wait_rel = 1'b0, io_was_low = 1'b0;
   int         nw = 1, wk = 0;

   assign dbus       = (!rd_n && !iorq_n) ? dev_drv : 8'bz;
   assign bus_wait_n = iorq_n | wait_rel;

   always @(posedge hi_stb_n) hi_latch = abus;

   always @(posedge wr_n) begin
      if (iorq_n === 1'b0) begin
         pm[{hi_latch, abus}] = dbus;
         chk(dbus_oe === 1'b1, "R8 data still driven at write strobe rise", dbus_oe, 1);
      end
   end

   always @(negedge clk) begin
      if (iorq_n === 1'b0) begin
         if (!io_was_low) begin
            io_was_low = 1'b1;
            nw = $urandom_range(8, 1);
            wk = 0;
            dev_drv = pm.exists({hi_latch, abus}) ? pm[{hi_latch, abus}] : dflt({hi_latch, abus});
         end else wk++;
         if (wk == nw) wait_rel = 1'b1;
      end else begin
         io_was_low = 1'b0;
         wait_rel   = 1'b0;
      end
   end

   // ---------------- scoreboard ----------------
   item_t      sb[$];
   logic [7:0] exp_mem [logic [15:0]];

   task automatic xact(input bit w, input logic [15:0] a, input logic [7:0] d);
      item_t it;
      it.wr   = w;
      it.addr = a;
      it.data = w ? d : (exp_mem.exists(a) ? exp_mem[a] : dflt(a));
      if (w) exp_mem[a] = d;
      sb.push_back(it);
      n_issued++;
      @(negedge clk);
      start = 1'b1; wr_sel = w; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      while (n_done < n_issued) @(negedge clk);
      @(negedge clk);
   endtask

   // ---------------- monitor ----------------
   logic p_hl = 1'b1, p_io = 1'b1, p_rw = 1'b1, p_oe = 1'b0, p_done = 1'b0;
   int   hl_w = 0, c_hl = 0, c_io = 0, rw_at = 0;
   bit   rd_drive_bad = 1'b0;
   item_t cur;

   always @(negedge clk) begin
      if (!rst) begin
         if (sb.size() > 0) cur = sb[0];
         c_hl++; c_io++;
         if (p_hl && !hi_stb_n) begin hl_falls++; hl_w = 1; end
         else if (!hi_stb_n) hl_w++;
         if (!p_hl && hi_stb_n) begin
            chk(hl_w == 1, "R1 latch strobe width", hl_w, 1);
            chk(hi_latch == cur.addr[15:8], "R1 latched high byte", hi_latch, cur.addr[15:8]);
            c_hl = 0;
         end
         if (p_io && !iorq_n) begin
            c_io = 0;
            chk(c_hl == SETUP + 1, "R3 setup gap", c_hl, SETUP + 1);
            chk(abus == cur.addr[7:0], "R1 low byte on bus", abus, cur.addr[7:0]);
            if (cur.wr) begin
               chk(!wr_n && rd_n, "R4 write strobe with IORQ", {rd_n, wr_n}, 2'b10);
               chk(dbus_oe && dbus == cur.data, "R4 write data driven", dbus, cur.data);
            end else
               chk(!rd_n && wr_n, "R3 read strobe with IORQ", {rd_n, wr_n}, 2'b01);
         end
         if (!rd_n && dbus_oe) rd_drive_bad = 1'b1;
         if (!p_rw && rd_n && wr_n) begin
            rw_at = c_io;
            chk(c_io == ((STRB + 1 > nw + 4) ? STRB + 1 : nw + 4),
                "R5 R10 strobe length vs WAIT", c_io, (STRB + 1 > nw + 4) ? STRB + 1 : nw + 4);
            chk(!iorq_n, "R7 IORQ still low at strobe release", iorq_n, 0);
            if (!cur.wr) chk(rdata == cur.data, "R6 read data", rdata, cur.data);
         end
         if (!p_io && iorq_n)
            chk(c_io == rw_at + 1, "R7 IORQ rises one cycle after RD/WR", c_io, rw_at + 1);
         if (done) begin
            chk(!p_done, "R9 done single cycle", p_done, 0);
            chk(!dbus_oe && iorq_n && c_io == rw_at + 2, "R9 R8 done timing", c_io, rw_at + 2);
            if (cur.wr) chk(p_oe, "R8 enable held through release", p_oe, 1);
            else        chk(!rd_drive_bad, "R8 no drive in read", rd_drive_bad, 0);
            rd_drive_bad = 1'b0;
            if (sb.size() > 0) void'(sb.pop_front());
            else chk(1'b0, "R9 unexpected done", 1, 0);
            n_done++;
         end
      end
      p_hl = hi_stb_n; p_io = iorq_n; p_rw = rd_n & wr_n; p_oe = dbus_oe; p_done = done;
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) @(negedge clk);
      chk(iorq_n && rd_n && wr_n && hi_stb_n, "R2 strobes high in reset",
          {iorq_n, rd_n, wr_n, hi_stb_n}, 4'hF);
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(iorq_n && rd_n && wr_n && hi_stb_n, "R2 strobes high after reset",
          {iorq_n, rd_n, wr_n, hi_stb_n}, 4'hF);
      chk(!dbus_oe && !done, "R2 bus idle after reset", {dbus_oe, done}, 0);

      for (int i = 0; i < 6; i++) begin
         xact(1'b1, 16'h0001, (i % 2) ? 8'hAA : 8'h55);
         xact(1'b0, 16'h0001, 8'h00);
      end
      xact(1'b1, 16'hC3A5, 8'h3C);
      xact(1'b0, 16'hBEEF, 8'h00);
      xact(1'b0, 16'hC3A5, 8'h00);
      xact(1'b1, 16'h0100, 8'h01);
      xact(1'b0, 16'h0001, 8'h00);
      xact(1'b0, 16'h0100, 8'h00);

      // R9: start pulsed while busy must be ignored
      fork
         xact(1'b1, 16'h0001, 8'h55);
         begin
            repeat (6) @(negedge clk);
            start = 1'b1; wr_sel = 1'b0; addr = 16'h7777;
            @(negedge clk);
            start = 1'b0;
         end
      join
      repeat (8) @(negedge clk);
      chk(hl_falls == n_issued, "R9 busy start ignored (latch cycles)", hl_falls, n_issued);
      chk(n_done == n_issued, "R9 one done per transaction", n_done, n_issued);
      chk(iorq_n && hi_stb_n && !dbus_oe, "R2 idle after final transaction",
          {iorq_n, hi_stb_n, dbus_oe}, 3'b110);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule